// File: doc/BRIEF.md
# Second-order sigma-delta bitstream generator

This block is an all-digital second-order delta-sigma modulator. It takes a signed 16-bit sample and turns it into a single-bit stream whose density of ones tracks the sample's position in the full-scale range. Alongside the stream it produces a modulator clock, derived from the system clock, that frames each bit. Its main use is as a stand-in for an isolated analog modulator front end, so that decimation filters can be exercised with a known, repeatable bitstream.

The input word is read as a normalized differential level. The value +32767 is positive full scale and -32767 is negative full scale. The loop has two cascaded saturating integrators and a one-bit quantizer that makes one decision per modulator clock period. The second integrator sees the first integrator's new value within the same step. Each integrator subtracts a feedback of plus or minus full scale, chosen by the previous output bit. Internally the datapath is the input shifted left by two, plus four guard bits. Reset puts both integrators at the zero-input equilibrium of the loop, so a zero input gives a clean alternating pattern from the very first bit.

Top module: `sdm2_stream_gen`

## Requirements
- R1: A synchronous active-high reset drives `mod_clk` and `mod_bit` low. One cycle after any cycle with `rst` high, both outputs read 0.
- R2: `mod_clk` has the system clock frequency divided by `DIV` (even, at least 2). Every high phase and every low phase lasts exactly `DIV/2` system cycles. This includes the first low phase counted from the last reset cycle.
- R3: `mod_bit` changes only on the system clock edge that raises `mod_clk`. It holds its value from that rising edge through the following falling edge of `mod_clk`.
- R4: With `sample_in` held at 0 since reset, the stream alternates every modulator period and starts with a 1. Any 4096-period window therefore holds exactly 2048 ones.
- R5: At +25599 (250/320 of full scale), a 4096-period window holds 3648 ± 2 ones (89.06%). At -25599 it holds 448 ± 2 ones (10.94%).
- R6: With `sample_in` held at +32767 since reset, every bit is 1 from the first modulator period on. The integrators saturate instead of wrapping, so the stream keeps its value however long the input is held.
- R7: With `sample_in` held at -32767 since reset, every bit from the third modulator period on is 0.
- R8: An input of -32768 is clamped to -32767 before it reaches the first integrator. It behaves exactly as in R7.
- R9: For any constant input x within ±0.6 of full scale, the ones count over 4096 periods is within ±2 of 4096·(x+32767)/65534.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 16 | Signed input level; +32767 and -32767 are the full-scale points |
| mod_clk | output | 1 | Modulator framing clock, system clock divided by DIV, 50% duty |
| mod_bit | output | 1 | Serial one-bit stream, updated with each rising edge of mod_clk |

## Verification
The checker's zero-input and full-scale properties arm only when the input has stayed at that value in every cycle since reset. The phase-length property assumes that reset is held for at least one full cycle before release. The bench therefore changes `sample_in` only while reset is asserted, holds reset for five cycles, and keeps the input constant for a whole run. Its random levels are drawn within ±0.6 of full scale. This keeps the loop well inside its stable range, where the ±2 count bound of the density checks applies.

// File: rtl/sdm2_pkg.sv
`timescale 1ns/1ps
package sdm2_pkg;

    // Input word and internal datapath sizing
    localparam int IN_W       = 16;
    localparam int SCALE_SH   = 2;   // input pre-shift so equilibrium states are integers
    localparam int GUARD_W    = 4;
    localparam int ACC_W      = IN_W + SCALE_SH + GUARD_W;
    localparam int LOOP_ORDER = 2;

    // Full-scale code and derived feedback / equilibrium levels
    localparam int FS_CODE = (1 << (IN_W - 1)) - 1;
    localparam int FB_INT  = FS_CODE * (1 << SCALE_SH);
    localparam int I1_INT  = -(FB_INT / 2);
    localparam int I2_INT  = -((3 * FB_INT) / 4);

    typedef logic signed [IN_W-1:0]  sample_t;
    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [ACC_W+1:0] wide_t;

    typedef enum logic {
        MCLK_LOW  = 1'b0,
        MCLK_HIGH = 1'b1
    } mclk_phase_e;

    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam acc_t FB_POS  = acc_t'(FB_INT);
    localparam acc_t FB_NEG  = acc_t'(-FB_INT);

    // Clamp the most negative code onto -full-scale and scale into the datapath
    function automatic acc_t scale_input(input sample_t s);
        sample_t lim;
        lim = (s < -sample_t'(FS_CODE)) ? -sample_t'(FS_CODE) : s;
        return acc_t'(lim) <<< SCALE_SH;
    endfunction

    // One integrator step: acc + addend - feedback, saturated to the datapath
    function automatic acc_t sat_step(input acc_t acc, input acc_t addend, input acc_t fb);
        wide_t sum;
        sum = wide_t'(acc) + wide_t'(addend) - wide_t'(fb);
        if (sum > wide_t'(ACC_MAX)) return ACC_MAX;
        if (sum < wide_t'(ACC_MIN)) return ACC_MIN;
        return acc_t'(sum);
    endfunction

    // Feedback level chosen by the previous decision
    function automatic acc_t fb_level(input logic decision);
        return decision ? FB_POS : FB_NEG;
    endfunction

    // Zero-input equilibrium for each integrator stage
    function automatic acc_t stage_reset(input int k);
        return (k == 0) ? acc_t'(I1_INT) : acc_t'(I2_INT);
    endfunction

endpackage

// File: rtl/sdm2_clkgen.sv
`timescale 1ns/1ps
module sdm2_clkgen
    import sdm2_pkg::*;
#(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst,
    output logic step,
    output logic mod_clk
);

    localparam int HALF  = DIV / 2;
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_q;
    mclk_phase_e      phase_q;

    // The cycle whose closing edge raises the modulator clock
    assign step    = (cnt_q == CNT_W'(DIV - 1));
    assign mod_clk = (phase_q == MCLK_HIGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= CNT_W'(HALF);
            phase_q <= MCLK_LOW;
        end else if (step) begin
            cnt_q   <= '0;
            phase_q <= MCLK_HIGH;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(HALF - 1)) begin
                phase_q <= MCLK_LOW;
            end
        end
    end

endmodule

// File: rtl/sdm2_integrator.sv
`timescale 1ns/1ps
module sdm2_integrator
    import sdm2_pkg::*;
#(
    parameter acc_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  acc_t addend,
    input  acc_t feedback,
    output acc_t next_val
);

    acc_t acc_q;

    assign next_val = sat_step(acc_q, addend, feedback);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= RST_VAL;
        end else if (step) begin
            acc_q <= next_val;
        end
    end

endmodule

// File: rtl/sdm2_quantizer.sv
`timescale 1ns/1ps
module sdm2_quantizer
    import sdm2_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  acc_t level,
    output logic decision
);

    always_ff @(posedge clk) begin
        if (rst) begin
            decision <= 1'b0;
        end else if (step) begin
            decision <= (level >= 0);
        end
    end

endmodule

// File: rtl/sdm2_stream_gen.sv
`timescale 1ns/1ps
module sdm2_stream_gen
    import sdm2_pkg::*;
#(
    parameter int DIV = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic signed [IN_W-1:0] sample_in,
    output logic                   mod_clk,
    output logic                   mod_bit
);

    logic step;
    acc_t x_scaled;
    acc_t fb;
    acc_t stage_in  [LOOP_ORDER];
    acc_t stage_nxt [LOOP_ORDER];

    sdm2_clkgen #(.DIV(DIV)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .mod_clk (mod_clk)
    );

    assign x_scaled = scale_input(sample_in);
    assign fb       = fb_level(mod_bit);

    // Cascade: each stage after the first takes the previous stage's new value
    for (genvar k = 0; k < LOOP_ORDER; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign stage_in[k] = x_scaled;
        end else begin : g_tail
            assign stage_in[k] = stage_nxt[k-1];
        end

        sdm2_integrator #(.RST_VAL(stage_reset(k))) u_integ (
            .clk      (clk),
            .rst      (rst),
            .step     (step),
            .addend   (stage_in[k]),
            .feedback (fb),
            .next_val (stage_nxt[k])
        );
    end

    sdm2_quantizer u_quant (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .level    (stage_nxt[LOOP_ORDER-1]),
        .decision (mod_bit)
    );

endmodule

// File: rtl/sdm2_stream_gen_chk.sv
`timescale 1ns/1ps
module sdm2_stream_gen_chk
    import sdm2_pkg::*;
#(
    parameter int DIV = 20
) (
    input logic    clk,
    input logic    rst,
    input sample_t sample_in,
    input logic    mod_clk,
    input logic    mod_bit
);

    localparam int HALF = DIV / 2;

    logic last_clk;
    int   run_len;
    int   rise_cnt;
    logic zero_held;
    logic pos_held;
    logic neg_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_clk  <= 1'b0;
            run_len   <= 0;
            rise_cnt  <= 0;
            zero_held <= 1'b1;
            pos_held  <= 1'b1;
            neg_held  <= 1'b1;
        end else begin
            last_clk <= mod_clk;
            run_len  <= (mod_clk != last_clk) ? 1 : run_len + 1;
            if (mod_clk && !last_clk && rise_cnt < 3) rise_cnt <= rise_cnt + 1;
            if (sample_in != '0) zero_held <= 1'b0;
            if (sample_in != sample_t'(FS_CODE)) pos_held <= 1'b0;
            if (sample_in > -sample_t'(FS_CODE)) neg_held <= 1'b0;
        end
    end

    // R1: outputs are low the cycle after reset
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> (!mod_clk && !mod_bit));

    // R2: every phase of the modulator clock lasts DIV/2 system cycles
    assert_half_period_R2: assert property (@(posedge clk) disable iff (rst)
        (mod_clk != last_clk) |-> (run_len == HALF));

    // R3: the data bit moves only with a rising modulator clock
    assert_bit_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (mod_bit != $past(mod_bit)) |-> $rose(mod_clk));

    // R4: zero input held since reset alternates every period
    assert_zero_alternates_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_clk) && zero_held) |-> (mod_bit != $past(mod_bit)));

    // R6: positive full scale held since reset gives ones only
    assert_full_pos_ones_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_clk) && pos_held) |-> mod_bit);

    // R7 / R8: negative full scale (or clamped code) gives zeros from period three
    assert_full_neg_zeros_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_clk) && neg_held && rise_cnt >= 2) |-> !mod_bit);

endmodule

bind sdm2_stream_gen sdm2_stream_gen_chk #(.DIV(DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .mod_clk   (mod_clk),
    .mod_bit   (mod_bit)
);

// File: tb/sdm2_stream_gen_bench.sv
`timescale 1ns/1ps
module sdm2_stream_gen_bench;

    localparam int DIV      = 4;
    localparam int HALF     = DIV / 2;
    localparam int WIN      = 4096;
    localparam int WARM     = 8;
    localparam int FS       = 32767;
    localparam int WATCHDOG = 195000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] sample_in = '0;
    logic               mod_clk;
    logic               mod_bit;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sdm2_stream_gen #(.DIV(DIV)) u_sdm2_stream_gen (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .mod_clk   (mod_clk),
        .mod_bit   (mod_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic real ideal_ones(input int x);
        int xc;
        xc = (x < -FS) ? -FS : x;
        return real'(WIN) * real'(xc + FS) / (2.0 * real'(FS));
    endfunction

    task automatic apply_reset(input logic signed [15:0] v);
        sample_in = v;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check(!mod_clk && !mod_bit, "R1", "outputs during reset",
              {mod_clk, mod_bit}, 0);
        rst = 1'b0;
    endtask

    task automatic capture(input int periods, inout bit prev, output int ones,
                           output int alt_bad, output int hold_bad, output bit first_b);
        ones = 0; alt_bad = 0; hold_bad = 0; first_b = 1'b0;
        for (int p = 0; p < periods; p++) begin
            bit b;
            @(posedge mod_clk);
            #1;
            b = mod_bit;
            if (p == 0) first_b = b;
            if (b == prev) alt_bad++;
            prev = b;
            if (b) ones++;
            @(negedge mod_clk);
            #1;
            if (mod_bit != b) hold_bad++;
        end
    endtask

    // Reset, warm up, then count ones over one window
    task automatic run_const(input logic signed [15:0] v, output int w_ones,
                             output int alt_total, output bit first_b);
        bit prev;
        int o1, a1, h1, a2, h2;
        bit f2;
        apply_reset(v);
        prev = 1'b0;
        capture(WARM, prev, o1, a1, h1, first_b);
        capture(WIN,  prev, w_ones, a2, h2, f2);
        alt_total = a1 + a2;
        check((h1 + h2) == 0, "R3", "bit changed before falling edge", h1 + h2, 0);
    endtask

    task automatic check_density(input string req, input int x, input int ones);
        real ideal;
        ideal = ideal_ones(x);
        check((real'(ones) - ideal) <= 2.0 && (ideal - real'(ones)) <= 2.0,
              req, $sformatf("ones count for input %0d", x), ones, $rtoi(ideal + 0.5));
    endtask

    initial begin
        int  ones, alt;
        bit  first_b;
        void'($urandom(32'd7411));

        // R2: phase lengths of the modulator clock, measured from reset release
        begin
            logic lvl;
            int   run, seen, bad;
            apply_reset(16'sd0);
            lvl = mod_clk; run = 1; seen = 0; bad = 0;
            while (seen < 10) begin
                @(posedge clk);
                #1;
                if (mod_clk == lvl) run++;
                else begin
                    if (run != HALF) bad++;
                    seen++;
                    lvl = mod_clk;
                    run = 1;
                end
            end
            check(bad == 0, "R2", "phases not DIV/2 cycles long", bad, 0);
        end

        // R4: zero input alternates from the first bit
        run_const(16'sd0, ones, alt, first_b);
        check(alt == 0, "R4", "repeated bits at zero input", alt, 0);
        check(first_b == 1'b1, "R4", "first bit at zero input", first_b, 1);
        check(ones == WIN / 2, "R4", "ones at zero input", ones, WIN / 2);

        // R5: specified-performance points
        run_const(16'sd25599, ones, alt, first_b);
        check_density("R5", 25599, ones);
        run_const(-16'sd25599, ones, alt, first_b);
        check_density("R5", -25599, ones);

        // R6: positive full scale, all ones
        run_const(16'sd32767, ones, alt, first_b);
        check(first_b == 1'b1, "R6", "first bit at +full scale", first_b, 1);
        check(ones == WIN, "R6", "ones at +full scale", ones, WIN);

        // R7: negative full scale, all zeros after settling
        run_const(-16'sd32767, ones, alt, first_b);
        check(ones == 0, "R7", "ones at -full scale", ones, 0);

        // R8: most negative code clamps to negative full scale
        run_const(16'sh8000, ones, alt, first_b);
        check(ones == 0, "R8", "ones at clamped -32768", ones, 0);

        // R9: random constant levels within +-0.6 of full scale
        for (int i = 0; i < 2; i++) begin
            int x;
            x = int'($urandom_range(39320)) - 19660;
            run_const(16'(x), ones, alt, first_b);
            check_density("R9", x, ones);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", WATCHDOG, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule